// File: doc/BRIEF.md
# Stop-Clocked Thermometer Time Capture

This block is the digital capture and readout stage of a flip-flop based time-to-digital converter. It receives eight delayed copies of a start pulse, one per tap of a delay line that sits outside the block. Tap 0 has the shortest delay and tap 7 the longest. On the rising edge of a stop signal, a register bank clocked by that edge samples every tap. A tap whose delayed start has already risen reads 1. A tap whose delayed start is still low reads 0. The number of ones in the sampled word therefore measures the start-to-stop interval in units of one delay step, which is about 75 ps.

Before the taps are used, the start pulse is gated with a start-enable input. This gives the block a clear sequence: pull enable low, wait a short while, then apply a stop edge. That edge loads an all-zero word. The stop edge also passes through a two-flop synchronizer into the system clock domain. One cycle after the synchronized edge is detected, the block registers three outputs: the raw word, its ones-count, and a flag that marks a word that is not a clean thermometer code.

Top module: `tdc_capture`

## Requirements
- R1: The capture word has one bit per tap. Bit k holds the level of tap input k at the stop rising edge. Tap 0 has the shortest delay and is bit 0.
- R2: A bit reads 1 when its delayed start rose before the stop edge and 0 when it rose after. When tap k is delayed by (k+1) steps, a phase of p steps, with p not a whole number, gives ones at exactly the taps k with k+1 < p.
- R3: `count_o` is a 4-bit unsigned value equal to the number of ones in `raw_o`. It ranges from 0 to 8.
- R4: While `start_en_i` is low at the stop edge, every captured bit is 0, whatever the tap inputs are.
- R5: Clear sequence: with `start_en_i` low, a stop rising edge leaves `raw_o` = 0, `count_o` = 0 and `bubble_o` = 0.
- R6: `bubble_o` is 1 exactly when the captured word has a 0 at some index i and a 1 at a higher index j > i. Otherwise it is 0.
- R7: The stop edge is first sampled at the next `clk_i` rising edge (E1). The outputs take the new capture at the third rising edge (E3) and still show the old values between E2 and E3. `stop_i` must stay high for at least three clock periods.
- R8: Without a new stop rising edge, the outputs hold their values while taps and enable change.
- R9: Synchronous active-high `rst_i` sets `raw_o`, `count_o` and `bubble_o` to 0.
- R10: In a phase sweep in one-step increments starting below one step, the count rises by exactly one per step until it saturates at 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for synchronizer and readout |
| rst_i | input | 1 | Synchronous active-high reset |
| start_en_i | input | 1 | Start enable; gates every tap when low |
| tap_i | input | 8 | Delayed start copies, tap 0 least delayed |
| stop_i | input | 1 | Stop signal; its rising edge clocks the capture bank |
| raw_o | output | 8 | Captured thermometer word |
| count_o | output | 4 | Number of ones in the captured word |
| bubble_o | output | 1 | Captured word is not a contiguous run from tap 0 |

## Verification
A stuck or misordered capture flop shows at the ports as a wrong count or a spurious bubble flag on the third clock after the stop edge. It appears in the first sweep step that drives that tap. A broken enable gate shows as a nonzero word after a clear sequence. A synchronizer with the wrong depth moves the update by a cycle, and the check between E2 and E3 catches that, as does the check one cycle later. A stray load from tap or enable activity without a stop edge changes outputs that must hold, and it is seen at the next sample.

// File: rtl/tdc_pkg.sv
`timescale 1ps/1ps
package tdc_pkg;
    localparam int NUM_TAPS = 8;
    localparam int CNT_W    = $clog2(NUM_TAPS + 1);

    typedef logic [NUM_TAPS-1:0] tap_word_t;
    typedef logic [CNT_W-1:0]    tap_cnt_t;

    typedef struct packed {
        tap_word_t raw;
        tap_cnt_t  cnt;
        logic      bubble;
    } tdc_result_t;

    function automatic tap_cnt_t f_ones(input tap_word_t w);
        tap_cnt_t n = '0;
        for (int i = 0; i < NUM_TAPS; i++) begin
            n = n + tap_cnt_t'(w[i]);
        end
        return n;
    endfunction

    // A 1 found after any 0, walking upward from tap 0, breaks the code.
    function automatic logic f_bubble(input tap_word_t w);
        logic gap = 1'b0;
        logic bad = 1'b0;
        for (int i = 0; i < NUM_TAPS; i++) begin
            if (!w[i]) gap = 1'b1;
            else if (gap) bad = 1'b1;
        end
        return bad;
    endfunction
endpackage

// File: rtl/tdc_tap_gate.sv
`timescale 1ps/1ps
module tdc_tap_gate
    import tdc_pkg::*;
(
    input  logic      en_i,
    input  tap_word_t tap_i,
    output tap_word_t gated_o
);
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_gate
        assign gated_o[k] = tap_i[k] & en_i;
    end
endmodule

// File: rtl/tdc_capture_bank.sv
`timescale 1ps/1ps
module tdc_capture_bank
    import tdc_pkg::*;
(
    input  logic      stop_i,
    input  tap_word_t tap_i,
    output tap_word_t word_o
);
    // One comparator flop per tap, all clocked by the measured stop event.
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_stage
        logic q;
        always_ff @(posedge stop_i) begin
            q <= tap_i[k];
        end
        assign word_o[k] = q;
    end
endmodule

// File: rtl/tdc_edge_sync.sv
`timescale 1ps/1ps
module tdc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;

    // R7: one detection per stop edge
    p_single_pulse_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tdc_readout.sv
`timescale 1ps/1ps
module tdc_readout
    import tdc_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        load_i,
    input  tap_word_t   word_i,
    output tdc_result_t res_o
);
    tdc_result_t res_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            res_q <= '0;
        end else if (load_i) begin
            res_q.raw    <= word_i;
            res_q.cnt    <= f_ones(word_i);
            res_q.bubble <= f_bubble(word_i);
        end
    end

    assign res_o = res_q;

    // R8: result only moves on a detected stop edge
    p_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> $stable(res_q));
endmodule

// File: rtl/tdc_capture.sv
`timescale 1ps/1ps
module tdc_capture
    import tdc_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                start_en_i,
    input  logic [NUM_TAPS-1:0] tap_i,
    input  logic                stop_i,
    output logic [NUM_TAPS-1:0] raw_o,
    output logic [CNT_W-1:0]    count_o,
    output logic                bubble_o
);
    tap_word_t   gated;
    tap_word_t   captured;
    logic        stop_rise;
    tdc_result_t res;

    tdc_tap_gate u_gate (
        .en_i    (start_en_i),
        .tap_i   (tap_i),
        .gated_o (gated)
    );

    tdc_capture_bank u_bank (
        .stop_i (stop_i),
        .tap_i  (gated),
        .word_o (captured)
    );

    tdc_edge_sync #(.STAGES(2)) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (stop_i),
        .rise_o  (stop_rise)
    );

    tdc_readout u_read (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (stop_rise),
        .word_i (captured),
        .res_o  (res)
    );

    assign raw_o    = res.raw;
    assign count_o  = res.cnt;
    assign bubble_o = res.bubble;

    // R3: count never exceeds the tap count and matches the word
    p_count_bound_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        count_o <= CNT_W'(NUM_TAPS));
    p_count_raw_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        count_o == CNT_W'($countones(raw_o)));
    // R6: a clear flag implies a clean run of ones from tap 0
    p_thermo_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !bubble_o |-> ((raw_o & (raw_o + 1'b1)) == '0));
endmodule

// File: tb/tdc_capture_tb.sv
`timescale 1ps/1ps
module tdc_capture_tb;
    localparam int N       = 8;
    localparam int STEP_PS = 75;
    localparam int HALF_PS = 10000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         start_sig = 1'b0;
    logic         stop = 1'b0;
    logic [N-1:0] mask = '0;
    logic [N-1:0] model_tap;
    logic [N-1:0] tap_bus;
    logic [N-1:0] raw;
    logic [3:0]   cnt;
    logic         bub;
    int           n_run = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #(HALF_PS) clk = ~clk;

    for (genvar k = 0; k < N; k++) begin : g_line
        assign #((k + 1) * STEP_PS) model_tap[k] = start_sig;
    end
    assign tap_bus = model_tap ^ mask;

    tdc_capture u_dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .start_en_i (en),
        .tap_i      (tap_bus),
        .stop_i     (stop),
        .raw_o      (raw),
        .count_o    (cnt),
        .bubble_o   (bub)
    );

    function automatic logic [N-1:0] exp_word(input int phi, input logic e, input logic [N-1:0] m);
        logic [N-1:0] w;
        for (int k = 0; k < N; k++) w[k] = ((k + 1) * STEP_PS < phi);
        return (w ^ m) & {N{e}};
    endfunction

    function automatic int exp_ones(input logic [N-1:0] w);
        int n = 0;
        for (int k = 0; k < N; k++) n += w[k];
        return n;
    endfunction

    function automatic logic exp_bub(input logic [N-1:0] w);
        for (int i = 0; i < N; i++)
            for (int j = i + 1; j < N; j++)
                if (!w[i] && w[j]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // One measurement: start at a negative edge, stop phi ps later.
    task automatic measure(input int phi, input logic e, input logic [N-1:0] m, input string tag);
        logic [N-1:0] w = exp_word(phi, e, m);
        logic [N-1:0] old = raw;
        @(negedge clk);
        en = e; mask = m;
        start_sig = 1'b1;
        #(phi) stop = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(raw == old, {tag, " R7 hold before E3"}, raw, old);
        @(posedge clk);
        @(negedge clk);
        chk(raw == w, {tag, " R1 R2 raw"}, raw, w);
        chk(cnt == exp_ones(w), {tag, " R3 count"}, cnt, exp_ones(w));
        chk(bub == exp_bub(w), {tag, " R6 bubble"}, bub, exp_bub(w));
        stop = 1'b0;
        start_sig = 1'b0;
        mask = '0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int prev;
        logic [N-1:0] keep;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(raw == '0 && cnt == 0 && bub == 1'b0, "R9 reset state", {raw, cnt, bub}, 0);

        // R10 sweep with R2 boundaries
        prev = -1;
        for (int i = 0; i <= 10; i++) begin
            measure(40 + i * STEP_PS, 1'b1, '0, "R10 sweep");
            if (prev >= 0)
                chk(int'(cnt) == ((prev < N) ? prev + 1 : N), "R10 step", cnt, (prev < N) ? prev + 1 : N);
            prev = cnt;
        end

        // R4 R5 clear sequence after a full word
        measure(900, 1'b1, '0, "R5 prefill");
        measure(900, 1'b0, '0, "R5 clear");
        chk(raw == '0 && cnt == 0 && bub == 1'b0, "R5 cleared", {raw, cnt, bub}, 0);
        measure(500, 1'b0, 8'hA5, "R4 enable low");

        // R6 bubble directed cases
        measure(340, 1'b1, 8'h20, "R6 high stray");
        measure(640, 1'b1, 8'h01, "R6 hole at tap0");
        measure(40,  1'b1, 8'h80, "R6 lone top");

        // R8 activity without a stop edge
        measure(415, 1'b1, '0, "R8 setup");
        keep = raw;
        @(negedge clk);
        start_sig = 1'b1; mask = 8'h3C; en = 1'b0;
        repeat (3) @(negedge clk);
        en = 1'b1; start_sig = 1'b0;
        repeat (3) @(negedge clk);
        chk(raw == keep && cnt == exp_ones(keep), "R8 outputs held", raw, keep);
        mask = '0;
        repeat (2) @(negedge clk);

        // Random mix
        for (int r = 0; r < 40; r++) begin
            int ph = int'($urandom_range(0, 11)) * STEP_PS + 40;
            logic e = ($urandom_range(0, 7) != 0);
            logic [N-1:0] m = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
            measure(ph, e, m, "rand");
        end

        // R9 reset after a capture
        measure(700, 1'b1, '0, "R9 pre");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(raw == '0 && cnt == 0 && bub == 1'b0, "R9 reset clears", {raw, cnt, bub}, 0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule